// File: doc/BRIEF.md
# Self-Repairing Triplicated State Register

This block holds one state word in three flip-flop copies and keeps them in step on every clock. Each copy has its own majority voter, so no single voting point exists. On each edge every copy is reloaded from its own voter. When a write is pending, that voter looks at the three replicated next-state inputs. Otherwise it looks at the three stored copies. A single upset in one copy is therefore corrected at the next clock and cannot combine with a later upset in another copy.

Each of the three read outputs comes from its own voter over the stored copies, so downstream logic can stay triplicated. A flag reports any cycle in which the stored copies are not identical. A test port lets a bench flip one bit of one copy as that copy is loaded. This mimics a particle strike, and the bench can then watch the repair happen.

Top module: `tmr_refresh_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all three copies hold 0, so every read output is 0 and the disagreement flag is low.
- R2: When wr_en is high at a clock edge, every read output afterwards equals the bitwise majority of wr_data0, wr_data1 and wr_data2.
- R3: A write in which only one input replica differs from the other two leaves the three copies identical, so the disagreement flag is low after it.
- R4: When wr_en and inj_en are both low at an edge, the read outputs keep their previous value.
- R5: When inj_en is high at an edge and inj_copy is 0, 1 or 2, that copy (0, 1 or 2) stores the value it would have loaded with bit inj_bit inverted. In the following cycle the disagreement flag is high and all three read outputs still show the correct voted value.
- R6: At an edge where inj_en is low, a copy that was corrupted in a single bit is rewritten from its voter, so the disagreement flag is low afterwards and the read outputs are unchanged.
- R7: An injection that coincides with a write corrupts only the chosen copy of the newly written value. The read outputs show the written majority at once, and the corruption is gone one clock later.
- R8: The disagreement flag is high exactly in the cycles in which the three stored copies are not all equal.
- R9: An injection with inj_copy equal to 3 selects no copy and has no effect: the flag stays low and the outputs do not change.
- R10: The three read outputs are produced by separate voters and agree with each other whenever at most one copy is corrupted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load the voted input replicas at the next edge |
| wr_data0 | input | W | Next-state replica 0 |
| wr_data1 | input | W | Next-state replica 1 |
| wr_data2 | input | W | Next-state replica 2 |
| inj_en | input | 1 | Test: invert one bit of one copy at the next edge |
| inj_copy | input | 2 | Test: copy to corrupt (0 to 2; 3 selects none) |
| inj_bit | input | $clog2(W) | Test: bit position to invert |
| rd0 | output | W | Voted value from voter 0 |
| rd1 | output | W | Voted value from voter 1 |
| rd2 | output | W | Voted value from voter 2 |
| mismatch | output | 1 | Stored copies disagree |

## Verification
Repair is hard to observe because the outputs are voted and normally never show the corrupted copy. The only sign that repair happened is the disagreement flag rising for one cycle and then falling.

The bench uses the injection port to corrupt every bit of every copy, one at a time. It repeats this with the injection landing during a write. It also injects into different copies on back-to-back cycles, so that one repair and the next corruption happen on the same edge.

Voting over mixed input replicas is checked by an exhaustive sweep that sends every three-bit combination through every bit lane.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int COPIES = 3;
  localparam int MAXW   = 64;

  function automatic logic maj_bit(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [MAXW-1:0] maj_word(input logic [MAXW-1:0] a,
                                               input logic [MAXW-1:0] b,
                                               input logic [MAXW-1:0] c);
    logic [MAXW-1:0] r;
    for (int i = 0; i < MAXW; i++) r[i] = maj_bit(a[i], b[i], c[i]);
    return r;
  endfunction
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  import tmr_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = maj_bit(a[i], b[i], c[i]);
  end
endmodule

// File: rtl/tmr_copy_reg.sv
module tmr_copy_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] flip,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d ^ flip;
  end

  // R1: the copy holds zero in the first cycle after reset release
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == '0));
endmodule

// File: rtl/tmr_inject_decode.sv
module tmr_inject_decode #(
  parameter int W  = 8,
  parameter int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inj_en,
  input  logic [1:0]    inj_copy,
  input  logic [BW-1:0] inj_bit,
  output logic [W-1:0]  mask0,
  output logic [W-1:0]  mask1,
  output logic [W-1:0]  mask2
);
  logic [W-1:0] bit_mask;
  logic         hit0, hit1, hit2;

  assign bit_mask = W'(1) << inj_bit;
  assign hit0 = inj_en && (inj_copy == 2'd0);
  assign hit1 = inj_en && (inj_copy == 2'd1);
  assign hit2 = inj_en && (inj_copy == 2'd2);
  assign mask0 = hit0 ? bit_mask : '0;
  assign mask1 = hit1 ? bit_mask : '0;
  assign mask2 = hit2 ? bit_mask : '0;

  // R5: at most one copy is ever disturbed per edge, in at most one bit
  p_one_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|mask0, |mask1, |mask2}) &&
    ($countones(mask0) + $countones(mask1) + $countones(mask2) <= 1));

  // R9: copy code 3 must produce no disturbance
  p_code3_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_copy == 2'd3) |-> ((mask0 | mask1 | mask2) == '0));
endmodule

// File: rtl/tmr_refresh_reg.sv
module tmr_refresh_reg #(
  parameter int W  = 8,
  parameter int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data0,
  input  logic [W-1:0]  wr_data1,
  input  logic [W-1:0]  wr_data2,
  input  logic          inj_en,
  input  logic [1:0]    inj_copy,
  input  logic [BW-1:0] inj_bit,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic          mismatch
);
  import tmr_pkg::*;

  logic [W-1:0] store_q  [COPIES];
  logic [W-1:0] hold_vote[COPIES];
  logic [W-1:0] wr_vote  [COPIES];
  logic [W-1:0] next_d   [COPIES];
  logic [W-1:0] flip     [COPIES];

  tmr_inject_decode #(.W(W), .BW(BW)) u_inj (
    .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .inj_copy(inj_copy),
    .inj_bit(inj_bit), .mask0(flip[0]), .mask1(flip[1]), .mask2(flip[2])
  );

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    tmr_voter #(.W(W)) u_hold_vote (
      .a(store_q[0]), .b(store_q[1]), .c(store_q[2]), .y(hold_vote[k])
    );
    tmr_voter #(.W(W)) u_wr_vote (
      .a(wr_data0), .b(wr_data1), .c(wr_data2), .y(wr_vote[k])
    );
    assign next_d[k] = wr_en ? wr_vote[k] : hold_vote[k];
    tmr_copy_reg #(.W(W)) u_copy (
      .clk(clk), .rst_n(rst_n), .d(next_d[k]), .flip(flip[k]), .q(store_q[k])
    );
  end

  assign rd0 = hold_vote[0];
  assign rd1 = hold_vote[1];
  assign rd2 = hold_vote[2];
  assign mismatch = (store_q[0] != store_q[1]) || (store_q[1] != store_q[2]);

  // R2: a write shows the voted replicas on every output after the edge
  p_write_vote_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd0 == $past(W'(maj_word(MAXW'(wr_data0), MAXW'(wr_data1),
                                        MAXW'(wr_data2))))));
  // R4: no write, no injection: output holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inj_en) |=> $stable(rd0));
  // R6: with no injection at an edge, copies agree afterwards
  p_repair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |=> !mismatch);
  // R5: a selected injection shows as disagreement in the next cycle
  p_inject_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && inj_copy != 2'd3) |=> mismatch);
  // R10: separate voters agree
  p_voters_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 == rd1) && (rd1 == rd2));
endmodule

// File: tb/tb_tmr_refresh_reg.sv
`timescale 1ns/1ps
module tb_tmr_refresh_reg;
  localparam int W  = 8;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [W-1:0]  wr_data0 = '0, wr_data1 = '0, wr_data2 = '0;
  logic          inj_en = 1'b0;
  logic [1:0]    inj_copy = '0;
  logic [BW-1:0] inj_bit = '0;
  logic [W-1:0]  rd0, rd1, rd2;
  logic          mismatch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_refresh_reg #(.W(W), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_data2(wr_data2),
    .inj_en(inj_en), .inj_copy(inj_copy), .inj_bit(inj_bit),
    .rd0(rd0), .rd1(rd1), .rd2(rd2), .mismatch(mismatch)
  );

  // expected majority: a bit is set when at least two replicas carry it
  function automatic logic [W-1:0] vote(input logic [W-1:0] a, b, c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int n;
      n = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (n >= 2);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp_v, input logic exp_m);
    checks++;
    if (rd0 !== exp_v || rd1 !== exp_v || rd2 !== exp_v || mismatch !== exp_m) begin
      errors++;
      $display("FAIL %s: rd=%h/%h/%h mismatch=%b expected rd=%h mismatch=%b",
               req, rd0, rd1, rd2, mismatch, exp_v, exp_m);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; inj_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic write(input logic [W-1:0] a, b, c);
    wr_en = 1'b1; inj_en = 1'b0;
    wr_data0 = a; wr_data1 = b; wr_data2 = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic inject(input int copy, input int bitn, input logic wr);
    wr_en = wr; inj_en = 1'b1;
    inj_copy = 2'(copy); inj_bit = BW'(bitn);
    @(negedge clk);
    inj_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    @(negedge clk); @(negedge clk);
    check("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0, 1'b0);

    // R2: exhaustive three-bit combinations across every lane
    for (int p = 0; p < 4096; p++) begin
      logic [W-1:0] a, b, c;
      a = {4'(p), 4'(p >> 8)};
      b = {4'(p >> 4), 4'(p)};
      c = {4'(p >> 8), 4'(p >> 4)};
      write(a, b, c);
      check("R2 voted write", vote(a, b, c), 1'b0);
    end

    // R3: one divergent replica at each position
    for (int k = 0; k < 3; k++) begin
      write(k == 0 ? 8'h0F : 8'hA5, k == 1 ? 8'h3C : 8'hA5, k == 2 ? 8'hFF : 8'hA5);
      check("R3 masked replica", 8'hA5, 1'b0);
    end

    // R4: hold over idle cycles
    for (int i = 0; i < 4; i++) begin
      idle();
      check("R4 hold", 8'hA5, 1'b0);
    end

    // R5/R6/R8: every copy, every bit
    v = 8'h5A;
    write(v, v, v);
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < W; b++) begin
        inject(k, b, 1'b0);
        check("R5 injected copy", v, 1'b1);
        idle();
        check("R6 repaired", v, 1'b0);
      end
    end

    // R6/R8: back-to-back injections in different copies
    inject(0, 3, 1'b0);
    check("R8 first upset", v, 1'b1);
    inject(1, 3, 1'b0);
    check("R8 second copy after repair of first", v, 1'b1);
    inject(2, 5, 1'b0);
    check("R8 third copy", v, 1'b1);
    idle();
    check("R6 all repaired", v, 1'b0);

    // R7: injection landing on a write
    for (int k = 0; k < 3; k++) begin
      v = 8'(8'h11 * (k + 3));
      wr_data0 = v; wr_data1 = v; wr_data2 = v;
      inject(k, 2 * k + 1, 1'b1);
      check("R7 write with upset", v, 1'b1);
      idle();
      check("R7 repaired after write", v, 1'b0);
    end

    // R9: copy code 3 selects nothing
    for (int b = 0; b < W; b++) begin
      inject(3, b, 1'b0);
      check("R9 code 3 no effect", v, 1'b0);
    end

    // R10: voters agree during upsets (checked inside check for equality)
    inject(1, 7, 1'b0);
    check("R10 voters agree under upset", v, 1'b1);
    idle();
    check("R10 voters agree after repair", v, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule